// File: doc/BRIEF.md
# Bank-Register Address Translation Unit

This block widens a 16-bit CPU address into a 21-bit physical address. The logical space is split into eight windows of 8 KiB each. Every window has its own 8-bit bank register. The top three logical address bits choose the register. That register's bank number becomes the upper eight bits of the physical address, and the thirteen in-window offset bits pass through unchanged.

Software loads the registers with a single operation that supplies a data byte and a select mask. Every register whose mask bit is set takes the byte, so one load can retarget several windows at once. A read-back port returns the contents of any register chosen by index.

Three flag outputs classify the bank of the current translation. The hardware I/O page is bank $FF. On-board work RAM is bank $F8. Cartridge ROM is any bank with its top bit clear, so bank $00 is the first ROM page. Translation and the flags are combinational from the logical address and the current register contents. A load takes effect on the clock edge where it is presented.

Top module: `bank_mapper`

## Requirements
- R1: While reset is high on a clock edge, all eight bank registers become $00. After reset, every index on the read-back port returns $00.
- R2: The physical address equals {bank register[laddr[15:13]], laddr[12:0]}. Bits 20:13 hold the bank number and bits 12:0 hold the logical offset.
- R3: On a clock edge with ld_en high, every register n with ld_mask[n] = 1 takes ld_value. Bit n of the mask selects register n, so mask 8'h02 selects register 1.
- R4: On a load, registers whose mask bit is 0 keep their previous value.
- R5: When ld_en is low, no register changes, whatever the mask and value inputs hold.
- R6: A load whose mask is 8'h00 changes no register.
- R7: rd_value equals bank register rd_sel in the same cycle, with no clock delay.
- R8: is_io is 1 exactly when physical address bits 20:13 equal 8'hFF.
- R9: is_ram is 1 exactly when physical address bits 20:13 equal 8'hF8.
- R10: is_rom is 1 exactly when physical address bit 20 is 0. At most one of the three flags is high, and none is high for banks $80–$F7 and $F9–$FE.
- R11: A register written on one clock edge is used by the translation in the cycle that starts at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ld_en | input | 1 | Load strobe for the bank registers |
| ld_mask | input | 8 | Register select mask; bit n selects register n |
| ld_value | input | 8 | Bank number to load |
| rd_sel | input | 3 | Index of the register shown on rd_value |
| rd_value | output | 8 | Contents of the selected register |
| laddr | input | 16 | Logical CPU address |
| paddr | output | 21 | Translated physical address |
| is_io | output | 1 | Current bank is the I/O page ($FF) |
| is_ram | output | 1 | Current bank is work RAM ($F8) |
| is_rom | output | 1 | Current bank lies in ROM (bit 7 clear) |

## Verification
The assertions check on every cycle that each selected register captures the load byte, that every unselected or idle register holds its value, that the offset bits pass through, and that the three flags match the bank field and never overlap. Several properties are harder to express as assertions and come only from bench scenarios: the reset contents shown through the read-back port, multi-register loads that give identical results, a translation that uses a value loaded on the previous edge, and random mixes of loads and addresses that the reference model follows.

// File: rtl/bank_mapper_pkg.sv
package bank_mapper_pkg;

    localparam int LADDR_W  = 16;
    localparam int BANK_W   = 8;
    localparam int OFFS_W   = 13;
    localparam int SEL_W    = LADDR_W - OFFS_W;
    localparam int NUM_BANKS = 1 << SEL_W;
    localparam int PADDR_W  = BANK_W + OFFS_W;

    localparam logic [BANK_W-1:0] IO_BANK  = 8'hFF;
    localparam logic [BANK_W-1:0] RAM_BANK = 8'hF8;

    typedef logic [BANK_W-1:0] bank_t;
    typedef logic [SEL_W-1:0]  sel_t;

    typedef struct packed {
        bank_t               bank;
        logic [OFFS_W-1:0]   offs;
    } phys_t;

    typedef struct packed {
        logic io;
        logic ram;
        logic rom;
    } region_t;

    function automatic region_t classify(input bank_t b);
        region_t r;
        r.io  = (b == IO_BANK);
        r.ram = (b == RAM_BANK);
        r.rom = ~b[BANK_W-1];
        return r;
    endfunction

endpackage

// File: rtl/bank_regfile.sv
module bank_regfile
    import bank_mapper_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ld_en,
    input  logic [NUM_BANKS-1:0] ld_mask,
    input  bank_t                ld_value,
    output bank_t [NUM_BANKS-1:0] banks
);

    for (genvar i = 0; i < NUM_BANKS; i++) begin : g_reg
        bank_t q;
        always_ff @(posedge clk) begin
            if (rst)
                q <= '0;
            else if (ld_en && ld_mask[i])
                q <= ld_value;
        end
        assign banks[i] = q;

        // R3: selected register captures the load byte
        a_r3_masked_write: assert property (@(posedge clk) disable iff (rst)
            (ld_en && ld_mask[i]) |=> (banks[i] == $past(ld_value)));
        // R4, R5, R6: unselected or idle register holds
        a_r4_hold: assert property (@(posedge clk) disable iff (rst)
            !(ld_en && ld_mask[i]) |=> $stable(banks[i]));
        // R1: cleared after reset
        a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
            $past(rst) |-> (banks[i] == '0));
    end

endmodule

// File: rtl/addr_xlate.sv
module addr_xlate
    import bank_mapper_pkg::*;
(
    input  bank_t [NUM_BANKS-1:0] banks,
    input  logic [LADDR_W-1:0]    laddr,
    input  sel_t                  rd_sel,
    output phys_t                 phys,
    output bank_t                 rd_value
);

    sel_t win;
    assign win = laddr[LADDR_W-1 -: SEL_W];

    always_comb begin
        phys.bank = banks[win];
        phys.offs = laddr[OFFS_W-1:0];
    end

    assign rd_value = banks[rd_sel];

endmodule

// File: rtl/region_decode.sv
module region_decode
    import bank_mapper_pkg::*;
(
    input  bank_t   bank,
    output region_t region
);

    assign region = classify(bank);

endmodule

// File: rtl/bank_mapper.sv
module bank_mapper
    import bank_mapper_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ld_en,
    input  logic [7:0]  ld_mask,
    input  logic [7:0]  ld_value,
    input  logic [2:0]  rd_sel,
    output logic [7:0]  rd_value,
    input  logic [15:0] laddr,
    output logic [20:0] paddr,
    output logic        is_io,
    output logic        is_ram,
    output logic        is_rom
);

    bank_t [NUM_BANKS-1:0] banks;
    phys_t                 phys;
    region_t               region;

    bank_regfile u_regs (
        .clk      (clk),
        .rst      (rst),
        .ld_en    (ld_en),
        .ld_mask  (ld_mask),
        .ld_value (ld_value),
        .banks    (banks)
    );

    addr_xlate u_xlate (
        .banks    (banks),
        .laddr    (laddr),
        .rd_sel   (rd_sel),
        .phys     (phys),
        .rd_value (rd_value)
    );

    region_decode u_dec (
        .bank   (phys.bank),
        .region (region)
    );

    assign paddr  = phys;
    assign is_io  = region.io;
    assign is_ram = region.ram;
    assign is_rom = region.rom;

    // R2: offset bits pass straight through
    a_r2_offset: assert property (@(posedge clk) disable iff (rst)
        paddr[OFFS_W-1:0] == laddr[OFFS_W-1:0]);
    // R8: I/O flag only on the I/O page
    a_r8_io_page: assert property (@(posedge clk) disable iff (rst)
        is_io |-> (paddr[20:13] == 8'hFF));
    // R9: RAM flag only on the work RAM page
    a_r9_ram_page: assert property (@(posedge clk) disable iff (rst)
        is_ram |-> (paddr[20:13] == 8'hF8));
    // R10: flags never overlap
    a_r10_exclusive: assert property (@(posedge clk) disable iff (rst)
        $onehot0({is_io, is_ram, is_rom}));
    // R10: ROM flag tracks the top physical bit
    a_r10_rom_half: assert property (@(posedge clk) disable iff (rst)
        is_rom == !paddr[20]);

endmodule

// File: tb/bank_mapper_bench.sv
module bank_mapper_bench;

    logic        clk = 1'b0;
    logic        rst;
    logic        ld_en;
    logic [7:0]  ld_mask;
    logic [7:0]  ld_value;
    logic [2:0]  rd_sel;
    logic [7:0]  rd_value;
    logic [15:0] laddr;
    logic [20:0] paddr;
    logic        is_io, is_ram, is_rom;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [7:0] model [8];

    always #2 clk = ~clk;

    bank_mapper u_bank_mapper (
        .clk(clk), .rst(rst), .ld_en(ld_en), .ld_mask(ld_mask),
        .ld_value(ld_value), .rd_sel(rd_sel), .rd_value(rd_value),
        .laddr(laddr), .paddr(paddr), .is_io(is_io), .is_ram(is_ram),
        .is_rom(is_rom)
    );

    function automatic logic [20:0] exp_paddr(input logic [15:0] a);
        return {model[a[15:13]], a[12:0]};
    endfunction

    function automatic logic [2:0] exp_flags(input logic [7:0] b);
        return {b == 8'hFF, b == 8'hF8, ~b[7]};
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // check translation, flags and read-back for the current inputs
    task automatic check_outputs(input string req);
        logic [20:0] p;
        p = exp_paddr(laddr);
        chk({req, "/R2"}, 32'(paddr), 32'(p));
        chk({req, "/R8-flags"}, 32'({is_io, is_ram, is_rom}), 32'(exp_flags(p[20:13])));
        chk({req, "/R7"}, 32'(rd_value), 32'(model[rd_sel]));
    endtask

    // present one load on the next edge and update the model
    task automatic do_load(input logic en, input logic [7:0] m, input logic [7:0] v);
        @(negedge clk);
        ld_en = en; ld_mask = m; ld_value = v;
        @(posedge clk);
        if (en) for (int i = 0; i < 8; i++) if (m[i]) model[i] = v;
        @(negedge clk);
        ld_en = 1'b0;
    endtask

    task automatic probe(input logic [15:0] a, input logic [2:0] s, input string req);
        @(negedge clk);
        laddr = a; rd_sel = s;
        #1;
        check_outputs(req);
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++; checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; ld_en = 1'b0; ld_mask = '0; ld_value = '0;
        rd_sel = '0; laddr = '0;
        for (int i = 0; i < 8; i++) model[i] = 8'h00;
        // load garbage during reset: must be overridden (R1)
        @(negedge clk); ld_en = 1'b1; ld_mask = 8'hFF; ld_value = 8'h5A;
        repeat (3) @(posedge clk);
        @(negedge clk); rst = 1'b0; ld_en = 1'b0;

        // R1: every register reads 00 after reset
        for (int i = 0; i < 8; i++) probe(16'(i) << 13, 3'(i), "R1");

        // R3 typical setup, one-hot masks
        do_load(1'b1, 8'h01, 8'hFF);
        do_load(1'b1, 8'h02, 8'hF8);
        do_load(1'b1, 8'h80, 8'h00);
        probe(16'h0123, 3'd0, "R8");
        chk("R8", 32'(is_io), 32'd1);
        probe(16'h2ABC, 3'd1, "R9");
        chk("R9", 32'(is_ram), 32'd1);
        chk("R2", 32'(paddr), 32'h1F0ABC);
        probe(16'hFFFE, 3'd7, "R10");
        chk("R10", 32'(is_rom), 32'd1);
        chk("R2", 32'(paddr), 32'h001FFE);

        // R3/R4: multi-hot load of registers 2..6
        do_load(1'b1, 8'h7C, 8'hC3);
        for (int i = 0; i < 8; i++) probe(16'(i) << 13 | 16'h0055, 3'(i), "R4");
        probe(16'h4000, 3'd4, "R10");
        chk("R10", 32'({is_io, is_ram, is_rom}), 32'd0);

        // R5: ld_en low, full mask, no effect
        do_load(1'b0, 8'hFF, 8'h11);
        for (int i = 0; i < 8; i++) probe(16'(i) << 13, 3'(i), "R5");
        // R6: zero mask, no effect
        do_load(1'b1, 8'h00, 8'h22);
        for (int i = 0; i < 8; i++) probe(16'(i) << 13, 3'(i), "R6");

        // R11: value loaded on an edge is used right after it
        @(negedge clk);
        laddr = 16'hA010; rd_sel = 3'd5;
        ld_en = 1'b1; ld_mask = 8'h20; ld_value = 8'h37;
        @(posedge clk); model[5] = 8'h37;
        #1;
        check_outputs("R11");
        chk("R11", 32'(paddr), 32'h06E010);
        @(negedge clk); ld_en = 1'b0;

        // random mix of loads and lookups
        for (int n = 0; n < 400; n++) begin
            logic [7:0] v;
            case ($urandom % 4)
                0: v = 8'hFF;
                1: v = 8'hF8;
                default: v = 8'($urandom);
            endcase
            if ($urandom % 2) do_load(($urandom % 4) != 0, 8'($urandom), v);
            probe(16'($urandom), 3'($urandom), "R3");
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule